// File: doc/BRIEF.md
# Two-Stage APB Watchdog Timer

This block is a watchdog peripheral that sits on an APB slave port and takes 32-bit word accesses. A 32-bit down-counter steps once on every cycle in which the count-enable tick input is high. The first time it runs out, the block sets a raw interrupt flag and starts a fresh period. If software has not cleared the flag by the time the count runs out again, the block latches a reset request and stops the counter. Software restarts the count by writing a new load value, or by clearing the interrupt, which also reloads the counter.

Two separate enable bits gate the interrupt and reset outputs. A magic-key lock register protects all other registers against stray writes. A test-mode pair of registers can drive both outputs directly. Fixed identification bytes sit at the top of the 4 KiB window. A parameter selects a variant. In the variant, the test registers are absent, and once the interrupt enable has been set the control register ignores writes until reset.

Top module: `twostage_wdog`

## Requirements
- R1: After reset, the load register (0x000) and the count (0x004) both read 0xFFFFFFFF and the counter is running. Control (0x008), raw status (0x010), lock (0xC00) and test control (0xF00) read 0. Both outputs are low, pready is 1 and pslverr is 0.
- R2: A write to offset 0x000 stores the reload value and loads it into the count at that same clock edge. The counter runs from then on. Reading 0x000 returns the stored reload value and reading 0x004 returns the count.
- R3: The count drops by one on each tick. A tick that arrives while the count is 0 is an expiry. If bit 0 of 0x010 is clear at an expiry, the block sets that bit and reloads the count from the reload value.
- R4: At an expiry with bit 0 of 0x010 already set, the block latches the reset status and the counter stops at 0. The reset status stays set until reset, even if a new load value is written.
- R5: A write of any value to 0x00C clears bit 0 of 0x010 and reloads the count. A bus reload (a write to 0x000 or 0x00C) takes priority over a tick in the same cycle.
- R6: In control register 0x008, bit 0 enables the interrupt and bit 1 enables the reset. All other bits read 0. With test mode off, wdog_irq is the raw flag gated by bit 0 and wdog_rst_req is the reset status gated by bit 1. Offset 0x014 reads the gated interrupt in bit 0.
- R7: Writing 0x1ACCE551 to 0xC00 unlocks the block and writing any other value locks it. Reading 0xC00 returns 1 while locked. While locked, writes to any offset other than 0xC00 have no effect.
- R8: When bit 0 of 0xF00 is set, wdog_irq follows bit 1 of 0xF04 and wdog_rst_req follows bit 0 of 0xF04, overriding the normal logic. Reading 0xF00 returns its bit 0.
- R9: The identification words from 0xFD0 to 0xFFC read, in address order: 04,00,00,00,24,B8,1B,00,0D,F0,05,B1.
- R10: Reads of write-only offsets (0x00C, 0xF04) and of unmapped offsets return 0. Writes to read-only offsets such as 0x010 are ignored.
- R11: With VARIANT=1, the block ignores writes to 0xF00 and 0xF04, and reads of those offsets return 0. Once control bit 0 is set, writes to 0x008 are ignored until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| cnt_tick | input | 1 | Count enable: one decrement per high cycle |
| wdog_irq | output | 1 | Interrupt request |
| wdog_rst_req | output | 1 | Reset request |

## Verification
Register writes take effect at the clock edge that ends the access phase, and the outputs are decoded without further registers from the updated state. The bench therefore samples the pins one time unit after that edge. Read data is combinational during the access phase, so the monitor compares it at the falling edge inside that phase against the expected value the driver queued. A tick run of n cycles moves the count n steps by the edge that ends the run, and an expiry's reload or stop is visible on the same edge. Every check is taken after the run returns, never while it is in progress.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DATA_W = 32;
  localparam int OFS_W  = 12;

  localparam logic [OFS_W-1:0] OFS_RELOAD = 12'h000;
  localparam logic [OFS_W-1:0] OFS_COUNT  = 12'h004;
  localparam logic [OFS_W-1:0] OFS_CTRL   = 12'h008;
  localparam logic [OFS_W-1:0] OFS_ACK    = 12'h00C;
  localparam logic [OFS_W-1:0] OFS_RAW    = 12'h010;
  localparam logic [OFS_W-1:0] OFS_MASKED = 12'h014;
  localparam logic [OFS_W-1:0] OFS_KEY    = 12'hC00;
  localparam logic [OFS_W-1:0] OFS_TSTEN  = 12'hF00;
  localparam logic [OFS_W-1:0] OFS_TSTOUT = 12'hF04;
  localparam logic [OFS_W-1:0] OFS_IDLO   = 12'hFD0;

  // Byte held by identification word number idx (0 = lowest address).
  function automatic logic [7:0] id_byte(input logic [3:0] idx);
    case (idx)
      4'd0:    return 8'h04;
      4'd4:    return 8'h24;
      4'd5:    return 8'hB8;
      4'd6:    return 8'h1B;
      4'd8:    return 8'h0D;
      4'd9:    return 8'hF0;
      4'd10:   return 8'h05;
      4'd11:   return 8'hB1;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             reload,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             halt,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             expire
);
  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] c);
    return c - CNT_W'(1);
  endfunction

  // A bus reload in the same cycle suppresses the expiry.
  assign expire = tick && running && (count == '0) && !reload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '1;
      running <= 1'b1;
    end else if (reload) begin
      count   <= reload_val;
      running <= 1'b1;
    end else if (expire) begin
      if (halt) running <= 1'b0;
      else      count   <= reload_val;
    end else if (tick && running) begin
      count <= step_down(count);
    end
  end
endmodule

// File: rtl/wdog_expiry_ctl.sv
module wdog_expiry_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clr,
  output logic raw,
  output logic rstat,
  output logic halt
);
  assign halt = expire && raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw   <= 1'b0;
      rstat <= 1'b0;
    end else begin
      if (clr)                 raw <= 1'b0;
      else if (expire && !raw) raw <= 1'b1;
      if (halt)                rstat <= 1'b1;
    end
  end
endmodule

// File: rtl/wdog_outsel.sv
module wdog_outsel (
  input  logic       tst_en,
  input  logic [1:0] tst_out,
  input  logic       raw,
  input  logic       rstat,
  input  logic       int_en,
  input  logic       rst_en,
  output logic       irq,
  output logic       rst_req
);
  always_comb begin
    if (tst_en) begin
      irq     = tst_out[1];
      rst_req = tst_out[0];
    end else begin
      irq     = raw && int_en;
      rst_req = rstat && rst_en;
    end
  end
endmodule

// File: rtl/twostage_wdog.sv
module twostage_wdog
  import wdog_pkg::*;
#(
  parameter int          VARIANT    = 0,
  parameter int          CNT_W      = 32,
  parameter logic [31:0] UNLOCK_KEY = 32'h1ACCE551
) (
  input  logic        pclk,
  input  logic        presetn,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [11:0] paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  output logic        pready,
  output logic        pslverr,
  input  logic        cnt_tick,
  output logic        wdog_irq,
  output logic        wdog_rst_req
);
  localparam bit HAS_TEST = (VARIANT == 0);

  logic [OFS_W-1:0] ofs;
  logic             aligned;
  logic             wr_en, wr_ok, wr_load, wr_ctrl, wr_clr, wr_key;
  logic             bus_reload, ctrl_frozen;
  logic [CNT_W-1:0] load_val, reload_val, count;
  logic             running, expire, halt, raw, rstat;
  logic             int_en, rst_en, locked;
  logic             tst_en;
  logic [1:0]       tst_out;
  logic [DATA_W-1:0] rd_word;

  assign ofs         = paddr;
  assign aligned     = (paddr[1:0] == 2'b00);
  assign wr_en       = psel && penable && pwrite && aligned;
  assign wr_key      = wr_en && (ofs == OFS_KEY);
  assign wr_ok       = wr_en && !locked;
  assign ctrl_frozen = (VARIANT != 0) && int_en;
  assign wr_load     = wr_ok && (ofs == OFS_RELOAD);
  assign wr_ctrl     = wr_ok && (ofs == OFS_CTRL) && !ctrl_frozen;
  assign wr_clr      = wr_ok && (ofs == OFS_ACK);
  assign bus_reload  = wr_load || wr_clr;
  assign reload_val  = wr_load ? pwdata[CNT_W-1:0] : load_val;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      load_val <= '1;
      int_en   <= 1'b0;
      rst_en   <= 1'b0;
      locked   <= 1'b0;
    end else begin
      if (wr_load) load_val <= pwdata[CNT_W-1:0];
      if (wr_ctrl) begin
        int_en <= pwdata[0];
        rst_en <= pwdata[1];
      end
      if (wr_key) locked <= (pwdata != UNLOCK_KEY);
    end
  end

  generate
    if (HAS_TEST) begin : g_test
      always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) begin
          tst_en  <= 1'b0;
          tst_out <= 2'b00;
        end else begin
          if (wr_ok && (ofs == OFS_TSTEN))  tst_en  <= pwdata[0];
          if (wr_ok && (ofs == OFS_TSTOUT)) tst_out <= pwdata[1:0];
        end
      end
    end else begin : g_no_test
      assign tst_en  = 1'b0;
      assign tst_out = 2'b00;
    end
  endgenerate

  wdog_counter #(.CNT_W(CNT_W)) u_counter (
    .clk        (pclk),
    .rst_n      (presetn),
    .tick       (cnt_tick),
    .reload     (bus_reload),
    .reload_val (reload_val),
    .halt       (halt),
    .count      (count),
    .running    (running),
    .expire     (expire)
  );

  wdog_expiry_ctl u_expiry (
    .clk    (pclk),
    .rst_n  (presetn),
    .expire (expire),
    .clr    (wr_clr),
    .raw    (raw),
    .rstat  (rstat),
    .halt   (halt)
  );

  wdog_outsel u_outsel (
    .tst_en  (tst_en),
    .tst_out (tst_out),
    .raw     (raw),
    .rstat   (rstat),
    .int_en  (int_en),
    .rst_en  (rst_en),
    .irq     (wdog_irq),
    .rst_req (wdog_rst_req)
  );

  always_comb begin
    rd_word = '0;
    if (aligned) begin
      case (ofs)
        OFS_RELOAD: rd_word = DATA_W'(load_val);
        OFS_COUNT:  rd_word = DATA_W'(count);
        OFS_CTRL:   rd_word = DATA_W'({rst_en, int_en});
        OFS_RAW:    rd_word = DATA_W'(raw);
        OFS_MASKED: rd_word = DATA_W'(raw && int_en);
        OFS_KEY:    rd_word = DATA_W'(locked);
        OFS_TSTEN:  rd_word = DATA_W'(tst_en);
        default: begin
          if (ofs >= OFS_IDLO) rd_word = DATA_W'(id_byte(ofs[5:2] - 4'd4));
        end
      endcase
    end
  end

  assign prdata  = rd_word;
  assign pready  = 1'b1;
  assign pslverr = 1'b0;
endmodule

// File: rtl/twostage_wdog_chk.sv
module twostage_wdog_chk #(
  parameter int VARIANT = 0,
  parameter int CNT_W   = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             wr_en,
  input logic [11:0]      ofs,
  input logic [31:0]      wdata,
  input logic             wr_load,
  input logic             wr_clr,
  input logic             bus_reload,
  input logic             expire,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] load_val,
  input logic             running,
  input logic             raw,
  input logic             rstat,
  input logic             int_en,
  input logic             rst_en,
  input logic             locked
);
  p_load_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_load |=> (count == $past(wdata[CNT_W-1:0])) && running);

  p_hold_without_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !bus_reload) |=> $stable(count));

  p_first_expiry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !raw) |=> raw && running && (count == load_val));

  p_second_expiry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && raw) |=> rstat && !running);

  p_reset_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rstat |=> rstat);

  p_clear_raw_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> !raw);

  p_locked_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && wr_en && (ofs != 12'hC00)) |=>
      $stable(int_en) && $stable(rst_en) && $stable(load_val) && $stable(locked));

  p_ctrl_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((VARIANT != 0) && int_en) |=> int_en);
endmodule

bind twostage_wdog twostage_wdog_chk #(.VARIANT(VARIANT), .CNT_W(CNT_W)) u_chk (
  .clk        (pclk),
  .rst_n      (presetn),
  .tick       (cnt_tick),
  .wr_en      (wr_en),
  .ofs        (ofs),
  .wdata      (pwdata),
  .wr_load    (wr_load),
  .wr_clr     (wr_clr),
  .bus_reload (bus_reload),
  .expire     (expire),
  .count      (count),
  .load_val   (load_val),
  .running    (running),
  .raw        (raw),
  .rstat      (rstat),
  .int_en     (int_en),
  .rst_en     (rst_en),
  .locked     (locked)
);

// File: tb/twostage_wdog_tb.sv
module twostage_wdog_tb;
  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel_a = 1'b0, psel_b = 1'b0;
  logic        penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic        cnt_tick = 1'b0;
  logic [31:0] prdata_a, prdata_b;
  logic        pready_a, pslverr_a, irq_a, rst_a;
  logic        pready_b, pslverr_b, irq_b, rst_b;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } sb_item_t;
  sb_item_t sb[$];

  always #5 pclk = ~pclk;

  twostage_wdog #(.VARIANT(0)) u_dut (
    .pclk(pclk), .presetn(presetn), .psel(psel_a), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata_a),
    .pready(pready_a), .pslverr(pslverr_a), .cnt_tick(cnt_tick),
    .wdog_irq(irq_a), .wdog_rst_req(rst_a));

  twostage_wdog #(.VARIANT(1)) u_dut_var (
    .pclk(pclk), .presetn(presetn), .psel(psel_b), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata_b),
    .pready(pready_b), .pslverr(pslverr_b), .cnt_tick(cnt_tick),
    .wdog_irq(irq_b), .wdog_rst_req(rst_b));

  // Monitor: compares read data in the access phase against the queue.
  always @(negedge pclk) begin
    if ((psel_a || psel_b) && penable && !pwrite) begin
      if (sb.size() == 0) begin
        n_checks++; n_fails++;
        $display("FAIL monitor: unexpected read, actual %h expected none",
                 psel_a ? prdata_a : prdata_b);
      end else begin
        sb_item_t it;
        logic [31:0] act;
        it  = sb.pop_front();
        act = psel_a ? prdata_a : prdata_b;
        n_checks++;
        if (act !== it.exp) begin
          n_fails++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic bus_cycle(input bit var_sel, input bit wr,
                           input logic [11:0] a, input logic [31:0] d);
    psel_a = !var_sel; psel_b = var_sel;
    penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
    @(posedge pclk); #1 penable = 1'b1;
    @(posedge pclk); #1 psel_a = 1'b0; psel_b = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic wr(input bit var_sel, input logic [11:0] a, input logic [31:0] d);
    bus_cycle(var_sel, 1'b1, a, d);
  endtask

  task automatic rd(input bit var_sel, input logic [11:0] a,
                    input logic [31:0] exp, input string tag);
    sb_item_t it;
    it.exp = exp; it.tag = tag;
    sb.push_back(it);
    bus_cycle(var_sel, 1'b0, a, 32'h0);
  endtask

  task automatic pin(input logic act, input logic exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    cnt_tick = 1'b1;
    repeat (n) @(posedge pclk);
    #1 cnt_tick = 1'b0;
  endtask

  task automatic do_reset();
    presetn = 1'b0;
    repeat (3) @(posedge pclk);
    #1 presetn = 1'b1;
    @(posedge pclk); #1;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge pclk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    rd(0, 12'h000, 32'hFFFF_FFFF, "R1 reload");
    rd(0, 12'h004, 32'hFFFF_FFFF, "R1 count");
    rd(0, 12'h008, 32'h0, "R1 ctrl");
    rd(0, 12'h010, 32'h0, "R1 raw");
    rd(0, 12'hC00, 32'h0, "R1 lock");
    rd(0, 12'hF00, 32'h0, "R1 test ctrl");
    pin(irq_a, 1'b0, "R1 irq");
    pin(rst_a, 1'b0, "R1 rst");
    pin(pready_a, 1'b1, "R1 pready");
    pin(pslverr_a, 1'b0, "R1 pslverr");
    // R9 identification bytes
    rd(0, 12'hFD0, 32'h04, "R9 id0");
    rd(0, 12'hFDC, 32'h00, "R9 id3");
    rd(0, 12'hFE0, 32'h24, "R9 id4");
    rd(0, 12'hFE4, 32'hB8, "R9 id5");
    rd(0, 12'hFE8, 32'h1B, "R9 id6");
    rd(0, 12'hFF0, 32'h0D, "R9 id8");
    rd(0, 12'hFF4, 32'hF0, "R9 id9");
    rd(0, 12'hFFC, 32'hB1, "R9 id11");
    // R10 write-only and unmapped reads
    rd(0, 12'h00C, 32'h0, "R10 ack read");
    rd(0, 12'hF04, 32'h0, "R10 test out read");
    rd(0, 12'h100, 32'h0, "R10 unmapped read");
    // R6 control bits
    wr(0, 12'h008, 32'hFFFF_FFFF);
    rd(0, 12'h008, 32'h3, "R6 ctrl stored bits");
    pin(irq_a, 1'b0, "R6 irq no raw");
    // R2 load
    wr(0, 12'h000, 32'd5);
    rd(0, 12'h004, 32'd5, "R2 count after load");
    rd(0, 12'h000, 32'd5, "R2 reload readback");
    // R3 countdown and first expiry
    ticks(3);
    rd(0, 12'h004, 32'd2, "R3 count after 3 ticks");
    ticks(2);
    rd(0, 12'h004, 32'd0, "R3 count at zero");
    ticks(1);
    rd(0, 12'h010, 32'h1, "R3 raw after expiry");
    rd(0, 12'h004, 32'd5, "R3 reloaded");
    pin(irq_a, 1'b1, "R6 irq gated on");
    rd(0, 12'h014, 32'h1, "R6 masked read");
    // R10 write to read-only ignored
    wr(0, 12'h010, 32'h0);
    rd(0, 12'h010, 32'h1, "R10 raw write ignored");
    // R5 clear with simultaneous tick
    ticks(2);
    rd(0, 12'h004, 32'd3, "R3 count 3");
    cnt_tick = 1'b1;
    wr(0, 12'h00C, 32'h1234);
    cnt_tick = 1'b0;
    rd(0, 12'h010, 32'h0, "R5 raw cleared");
    rd(0, 12'h004, 32'd5, "R5 bus reload beats tick");
    pin(irq_a, 1'b0, "R5 irq low after clear");
    // R4 second expiry
    ticks(6);
    rd(0, 12'h010, 32'h1, "R4 first expiry again");
    pin(rst_a, 1'b0, "R4 no reset after first");
    ticks(6);
    pin(rst_a, 1'b1, "R4 reset request");
    rd(0, 12'h004, 32'd0, "R4 stopped at zero");
    ticks(4);
    rd(0, 12'h004, 32'd0, "R4 still stopped");
    // R6 reset gating
    wr(0, 12'h008, 32'h1);
    pin(rst_a, 1'b0, "R6 rst masked");
    pin(irq_a, 1'b1, "R6 irq kept");
    wr(0, 12'h008, 32'h3);
    pin(rst_a, 1'b1, "R6 rst unmasked");
    // R7 lock
    wr(0, 12'hC00, 32'h0);
    rd(0, 12'hC00, 32'h1, "R7 locked");
    wr(0, 12'h008, 32'h0);
    rd(0, 12'h008, 32'h3, "R7 ctrl write ignored");
    wr(0, 12'h000, 32'd9);
    rd(0, 12'h004, 32'd0, "R7 load write ignored");
    rd(0, 12'h000, 32'd5, "R7 reload unchanged");
    wr(0, 12'hC00, 32'h1ACC_E551);
    rd(0, 12'hC00, 32'h0, "R7 unlocked");
    // R8 test override
    wr(0, 12'hF00, 32'h1);
    wr(0, 12'hF04, 32'h0);
    pin(irq_a, 1'b0, "R8 irq forced low");
    pin(rst_a, 1'b0, "R8 rst forced low");
    wr(0, 12'hF04, 32'h2);
    pin(irq_a, 1'b1, "R8 irq from bit1");
    pin(rst_a, 1'b0, "R8 rst from bit0");
    wr(0, 12'hF04, 32'h1);
    pin(irq_a, 1'b0, "R8 irq bit1 clear");
    pin(rst_a, 1'b1, "R8 rst bit0 set");
    rd(0, 12'hF00, 32'h1, "R8 test ctrl readback");
    wr(0, 12'hF00, 32'h0);
    pin(irq_a, 1'b1, "R8 normal irq back");
    pin(rst_a, 1'b1, "R8 normal rst back");
    // R4 sticky across new load
    wr(0, 12'h000, 32'd7);
    rd(0, 12'h004, 32'd7, "R2 restart after stop");
    pin(rst_a, 1'b1, "R4 reset status sticky");
    // R11 variant
    rd(1, 12'h008, 32'h0, "R11 variant ctrl reset");
    wr(1, 12'h008, 32'h1);
    rd(1, 12'h008, 32'h1, "R11 variant ctrl set");
    wr(1, 12'h008, 32'h2);
    rd(1, 12'h008, 32'h1, "R11 variant ctrl frozen");
    wr(1, 12'hF00, 32'h1);
    rd(1, 12'hF00, 32'h0, "R11 variant test ctrl absent");
    wr(1, 12'hF04, 32'h3);
    pin(irq_b, 1'b0, "R11 variant no irq override");
    pin(rst_b, 1'b0, "R11 variant no rst override");
    rd(1, 12'h00C, 32'h0, "R11 variant ack read");
    rd(1, 12'hFE4, 32'hB8, "R9 variant id5");
    // R1 after second reset
    do_reset();
    rd(0, 12'h004, 32'hFFFF_FFFF, "R1 count after reset");
    rd(0, 12'h010, 32'h0, "R1 raw after reset");
    rd(0, 12'h008, 32'h0, "R1 ctrl after reset");
    pin(rst_a, 1'b0, "R1 rst after reset");
    rd(1, 12'h008, 32'h0, "R11 variant unfrozen by reset");
    if (sb.size() != 0) begin
      n_checks++; n_fails++;
      $display("FAIL scoreboard: actual %0d left expected 0", sb.size());
    end
    done = 1'b1;
    summary();
  end
endmodule